// File: doc/BRIEF.md
# Register-Mapped GPIO Expander Bank

This block is a bank of 24 general-purpose pins. A byte-wide register port controls it: an address, a write byte with a strobe, and a read byte returned combinationally. The port has the shape that a serial slave front end presents after it decodes a transfer. The 24 pins form three bytes. Bytes 0 and 1 are the primary pins. Byte 2 holds the alternate pins, and this byte has its own enable.

Each pin carries four configuration bits: a direction bit, a drive-type bit, a pull-select bit and an output latch bit. The output latch never takes a plain write. It changes only through write-one-to-set and write-one-to-clear groups. Inputs pass through a two-flop synchronizer. Each pin can then raise an edge event or a level event. Events latch into pending bits, and a write of ones to an acknowledge group clears them. A single interrupt line is high while any pending bit is set.

The address is split into a group field in bits [7:2] and a byte index in bits [1:0]. Each register address is group*4 + byte, as the table below gives. Byte indices at or above the bank's byte count are unmapped.

| Group | Offset | Access |
|---|---|---|
| control (byte 0 only; bit0 primary enable, bit1 alternate enable) | 0x00 | RW |
| direction (1 = output) | 0x04 | RW |
| drive type | 0x08 | RW |
| pull select | 0x0C | RW |
| output set | 0x10 | W1S, reads 0 |
| output clear | 0x14 | W1C, reads 0 |
| pin level | 0x18 | RO |
| event enable | 0x1C | RW |
| event polarity (1 = rising/high) | 0x20 | RW |
| event kind (1 = edge, 0 = level) | 0x24 | RW |
| pending | 0x28 | RO |
| acknowledge | 0x2C | W1C, reads 0 |

Top module: `pinbank_top`

## Requirements
- R1: After reset, every register reads 0, and `gpio_o`, `gpio_oe_o`, `gpio_drv_o`, `gpio_pull_o` and `irq_o` are all 0.
- R2: The direction, drive, pull, event enable, polarity and kind groups read back the last byte written. The control register keeps only bits [1:0] and reads 0 in bits [7:2].
- R3: A write to the set group at 0x10+b sets the output bits of byte b where the write byte has a 1, from the next cycle. Bits written 0 keep their value. The set, clear and acknowledge groups always read 0.
- R4: A write to the clear group at 0x14+b clears the output bits of byte b where the write byte has a 1. Other bits keep their value.
- R5: `gpio_oe_o` is the direction bit ANDed with the pin's group enable: control bit0 for bytes 0..1 and bit1 for byte 2. `gpio_drv_o` and `gpio_pull_o` mirror the drive and pull groups.
- R6: The pin-level group reads the input value that was present two clock edges earlier (two-flop synchronizer).
- R7: With kind = 1, a pending bit sets one cycle after the synchronized level shows a rising edge (polarity 1) or a falling edge (polarity 0).
- R8: With kind = 0, the pending bit is set on every cycle in which the synchronized level equals the polarity bit.
- R9: A write of ones to the acknowledge group at 0x2C+b clears those pending bits. Bits written 0 are unaffected.
- R10: If an event occurs in the same cycle as its acknowledge, the pending bit stays set.
- R11: `irq_o` is high exactly when some pending bit is set. It falls only after an acknowledge.
- R12: No event is latched for a pin whose event enable is 0, or whose group enable in the control register is 0.
- R13: Unmapped addresses read 0, and writes to them change nothing: the group codes above 11, control bytes 1..3, and byte index 3 of any group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Register address: group in [7:2], byte in [1:0] |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Combinational read data for addr_i |
| gpio_i | input | 24 | Raw pin inputs |
| gpio_o | output | 24 | Output latch |
| gpio_oe_o | output | 24 | Output enable per pin |
| gpio_drv_o | output | 24 | Drive-type select per pin |
| gpio_pull_o | output | 24 | Pull-direction select per pin |
| irq_o | output | 1 | High while any pin event is pending |

## Verification
The bench targets four corner cases.

The first is an acknowledge that lands on the same edge as a new event. A design that gives the clear priority would lose that event, and `irq_o` would drop too early.

The second is a level-mode pin that is still active when it is acknowledged. Its pending bit must come straight back. A design that treats level mode as an edge would leave it clear.

The third is the alternate byte's enable. A design that gates only the output enable, and not event detection, would latch events on disabled pins.

The fourth is the synchronizer depth. A bench model that counts two edges catches a pin-level or event path that is one cycle short or one cycle long. Random write and pin traffic runs alongside these checks and compares every output and the read byte on every cycle.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int BSEL_W = 2;
  localparam int GRP_W  = 6;

  typedef enum logic [GRP_W-1:0] {
    G_CTRL  = 6'd0,
    G_DIR   = 6'd1,
    G_DRV   = 6'd2,
    G_PULL  = 6'd3,
    G_SET   = 6'd4,
    G_CLR   = 6'd5,
    G_STATE = 6'd6,
    G_IEN   = 6'd7,
    G_POL   = 6'd8,
    G_KIND  = 6'd9,
    G_PEND  = 6'd10,
    G_ACK   = 6'd11
  } grp_e;
endpackage

// File: rtl/pinbank_regs.sv
module pinbank_regs
  import pinbank_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int PW = 8 * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  grp_e              grp_i,
  input  logic [BSEL_W-1:0] bsel_i,
  input  logic [7:0]        wdata_i,
  output logic [1:0]        ctrl_o,
  output logic [PW-1:0]     dir_o,
  output logic [PW-1:0]     drv_o,
  output logic [PW-1:0]     pull_o,
  output logic [PW-1:0]     ien_o,
  output logic [PW-1:0]     pol_o,
  output logic [PW-1:0]     kind_o,
  output logic [PW-1:0]     out_o,
  output logic [PW-1:0]     ack_o
);
  logic [1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (we_i && grp_i == G_CTRL && bsel_i == '0) ctrl_q <= wdata_i[1:0];
  end
  assign ctrl_o = ctrl_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    logic       hit;
    logic [7:0] dir_q, drv_q, pull_q, ien_q, pol_q, kind_q, out_q;

    assign hit = we_i && (bsel_i == BSEL_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        dir_q  <= '0;
        drv_q  <= '0;
        pull_q <= '0;
        ien_q  <= '0;
        pol_q  <= '0;
        kind_q <= '0;
        out_q  <= '0;
      end else if (hit) begin
        case (grp_i)
          G_DIR:   dir_q  <= wdata_i;
          G_DRV:   drv_q  <= wdata_i;
          G_PULL:  pull_q <= wdata_i;
          G_IEN:   ien_q  <= wdata_i;
          G_POL:   pol_q  <= wdata_i;
          G_KIND:  kind_q <= wdata_i;
          G_SET:   out_q  <= out_q | wdata_i;
          G_CLR:   out_q  <= out_q & ~wdata_i;
          default: ;
        endcase
      end
    end

    assign dir_o[8*b +: 8]  = dir_q;
    assign drv_o[8*b +: 8]  = drv_q;
    assign pull_o[8*b +: 8] = pull_q;
    assign ien_o[8*b +: 8]  = ien_q;
    assign pol_o[8*b +: 8]  = pol_q;
    assign kind_o[8*b +: 8] = kind_q;
    assign out_o[8*b +: 8]  = out_q;
    assign ack_o[8*b +: 8]  = (hit && grp_i == G_ACK) ? wdata_i : 8'h00;
  end
endmodule

// File: rtl/pinbank_evt.sv
module pinbank_evt #(
  parameter int PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] pin_i,
  input  logic [PW-1:0] en_i,
  input  logic [PW-1:0] ien_i,
  input  logic [PW-1:0] pol_i,
  input  logic [PW-1:0] kind_i,
  output logic [PW-1:0] lvl_o,
  output logic [PW-1:0] evt_o
);
  logic [PW-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign lvl_o = sync_q;

  for (genvar i = 0; i < PW; i++) begin : g_pin
    logic cond;
    always_comb begin
      if (kind_i[i]) cond = pol_i[i] ? (sync_q[i] & ~prev_q[i]) : (~sync_q[i] & prev_q[i]);
      else           cond = pol_i[i] ? sync_q[i] : ~sync_q[i];
    end
    assign evt_o[i] = cond & ien_i[i] & en_i[i];
  end
endmodule

// File: rtl/pinbank_pend.sv
module pinbank_pend #(
  parameter int PW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] evt_i,
  input  logic [PW-1:0] ack_i,
  output logic [PW-1:0] pend_o
);
  logic [PW-1:0] pend_q;

  // a new event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~ack_i) | evt_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pinbank_top.sv
module pinbank_top
  import pinbank_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int PW = 8 * NUM_BYTES
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    addr_i,
  input  logic [7:0]    wdata_i,
  input  logic          we_i,
  output logic [7:0]    rdata_o,
  input  logic [PW-1:0] gpio_i,
  output logic [PW-1:0] gpio_o,
  output logic [PW-1:0] gpio_oe_o,
  output logic [PW-1:0] gpio_drv_o,
  output logic [PW-1:0] gpio_pull_o,
  output logic          irq_o
);
  grp_e              grp;
  logic [BSEL_W-1:0] bsel;
  logic              bvalid;
  logic [1:0]        ctrl;
  logic [PW-1:0]     dir, ien, pol, kind, ack, lvl, evt, pend, pin_en;

  assign grp    = grp_e'(addr_i[7:2]);
  assign bsel   = addr_i[1:0];
  assign bvalid = int'(bsel) < NUM_BYTES;

  pinbank_regs #(.NUM_BYTES(NUM_BYTES)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i && bvalid),
    .grp_i   (grp),
    .bsel_i  (bsel),
    .wdata_i (wdata_i),
    .ctrl_o  (ctrl),
    .dir_o   (dir),
    .drv_o   (gpio_drv_o),
    .pull_o  (gpio_pull_o),
    .ien_o   (ien),
    .pol_o   (pol),
    .kind_o  (kind),
    .out_o   (gpio_o),
    .ack_o   (ack)
  );

  // last byte is the alternate group
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_en
    if (b == NUM_BYTES - 1) begin : g_alt
      assign pin_en[8*b +: 8] = {8{ctrl[1]}};
    end else begin : g_pri
      assign pin_en[8*b +: 8] = {8{ctrl[0]}};
    end
  end

  assign gpio_oe_o = dir & pin_en;

  pinbank_evt #(.PW(PW)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (gpio_i),
    .en_i   (pin_en),
    .ien_i  (ien),
    .pol_i  (pol),
    .kind_i (kind),
    .lvl_o  (lvl),
    .evt_o  (evt)
  );

  pinbank_pend #(.PW(PW)) u_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .ack_i  (ack),
    .pend_o (pend)
  );

  assign irq_o = |pend;

  function automatic logic [7:0] pick(logic [PW-1:0] v, logic [BSEL_W-1:0] s);
    return 8'(v >> {s, 3'b000});
  endfunction

  always_comb begin
    rdata_o = '0;
    if (bvalid) begin
      case (grp)
        G_CTRL:  rdata_o = (bsel == '0) ? {6'b0, ctrl} : 8'h00;
        G_DIR:   rdata_o = pick(dir, bsel);
        G_DRV:   rdata_o = pick(gpio_drv_o, bsel);
        G_PULL:  rdata_o = pick(gpio_pull_o, bsel);
        G_STATE: rdata_o = pick(lvl, bsel);
        G_IEN:   rdata_o = pick(ien, bsel);
        G_POL:   rdata_o = pick(pol, bsel);
        G_KIND:  rdata_o = pick(kind, bsel);
        G_PEND:  rdata_o = pick(pend, bsel);
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int NUM_BYTES = 3,
  localparam int PW = 8 * NUM_BYTES
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    addr_i,
  input logic [7:0]    wdata_i,
  input logic          we_i,
  input logic [7:0]    rdata_o,
  input logic [PW-1:0] gpio_o,
  input logic          irq_o
);
  logic          bok, wr_set, wr_clr, wr_ack, rd_pend;
  logic [PW-1:0] wmask;

  assign bok     = int'(addr_i[1:0]) < NUM_BYTES;
  assign wmask   = PW'(wdata_i) << (8 * int'(addr_i[1:0]));
  assign wr_set  = we_i && bok && addr_i[7:2] == G_SET;
  assign wr_clr  = we_i && bok && addr_i[7:2] == G_CLR;
  assign wr_ack  = we_i && bok && addr_i[7:2] == G_ACK;
  assign rd_pend = bok && addr_i[7:2] == G_PEND;

  p_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((gpio_o & $past(wmask)) == $past(wmask)));

  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((gpio_o & $past(wmask)) == '0));

  p_out_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_set || wr_clr) |=> $stable(gpio_o));

  p_irq_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_ack) |=> irq_o);

  p_pend_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_pend && !irq_o) |-> rdata_o == 8'h00);
endmodule

bind pinbank_top pinbank_chk #(.NUM_BYTES(NUM_BYTES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .we_i    (we_i),
  .rdata_o (rdata_o),
  .gpio_o  (gpio_o),
  .irq_o   (irq_o)
);

// File: tb/pinbank_top_tb.sv
`timescale 1ns/1ps
module pinbank_top_tb;
  localparam int NB = 3;
  localparam int PW = 8 * NB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    addr = '0, wdata = '0;
  logic          we = 1'b0;
  logic [PW-1:0] gpio_in = '0;
  logic [7:0]    rdata;
  logic [PW-1:0] gpio_out, gpio_oe, gpio_drv, gpio_pull;
  logic          irq;

  int    nvec = 0, nerr = 0;
  bit    done = 0;
  string cur_req = "R1";

  pinbank_top #(.NUM_BYTES(NB)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_oe_o(gpio_oe),
    .gpio_drv_o(gpio_drv), .gpio_pull_o(gpio_pull), .irq_o(irq)
  );

  always #4 clk = ~clk;

  // reference state
  logic [1:0]    m_ctrl = '0;
  logic [PW-1:0] m_dir = '0, m_drv = '0, m_pull = '0, m_ien = '0, m_pol = '0;
  logic [PW-1:0] m_kind = '0, m_out = '0, m_pend = '0;
  logic [PW-1:0] hist[$] = '{'0, '0, '0};

  function automatic logic [PW-1:0] en_mask();
    logic [PW-1:0] m;
    for (int i = 0; i < PW; i++) m[i] = (i / 8 == NB - 1) ? m_ctrl[1] : m_ctrl[0];
    return m;
  endfunction

  task automatic model_step();
    logic [PW-1:0] lv, pv, ev, en, ackm;
    int g, b;
    lv = hist[1]; pv = hist[2]; en = en_mask(); ackm = '0;
    for (int i = 0; i < PW; i++) begin
      bit c;
      if (m_kind[i]) c = m_pol[i] ? (lv[i] && !pv[i]) : (!lv[i] && pv[i]);
      else           c = m_pol[i] ? lv[i] : !lv[i];
      ev[i] = c && m_ien[i] && en[i];
    end
    g = int'(addr) / 4; b = int'(addr) % 4;
    if (we && b < NB) begin
      case (g)
        0:  if (b == 0) m_ctrl = wdata[1:0];
        1:  m_dir[8*b +: 8]  = wdata;
        2:  m_drv[8*b +: 8]  = wdata;
        3:  m_pull[8*b +: 8] = wdata;
        4:  m_out[8*b +: 8]  = m_out[8*b +: 8] | wdata;
        5:  m_out[8*b +: 8]  = m_out[8*b +: 8] & ~wdata;
        7:  m_ien[8*b +: 8]  = wdata;
        8:  m_pol[8*b +: 8]  = wdata;
        9:  m_kind[8*b +: 8] = wdata;
        11: ackm[8*b +: 8]   = wdata;
        default: ;
      endcase
    end
    m_pend = (m_pend & ~ackm) | ev;
    hist.push_front(gpio_in);
    void'(hist.pop_back());
  endtask

  function automatic logic [7:0] exp_rd();
    int g, b;
    g = int'(addr) / 4; b = int'(addr) % 4;
    if (b >= NB) return 8'h00;
    case (g)
      0:  return (b == 0) ? {6'b0, m_ctrl} : 8'h00;
      1:  return m_dir[8*b +: 8];
      2:  return m_drv[8*b +: 8];
      3:  return m_pull[8*b +: 8];
      6:  return hist[1][8*b +: 8];
      7:  return m_ien[8*b +: 8];
      8:  return m_pol[8*b +: 8];
      9:  return m_kind[8*b +: 8];
      10: return m_pend[8*b +: 8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) model_step();
    #2;
    chk("rdata", 32'(rdata), 32'(exp_rd()));
    chk("gpio_o", 32'(gpio_out), 32'(m_out));
    chk("gpio_oe_o", 32'(gpio_oe), 32'(m_dir & en_mask()));
    chk("gpio_drv_o", 32'(gpio_drv), 32'(m_drv));
    chk("gpio_pull_o", 32'(gpio_pull), 32'(m_pull));
    chk("irq_o", 32'(irq), 32'(|m_pend));
  end

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a);
    addr = a;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    // R1: reset state and register scan
    cur_req = "R1";
    idle(3);
    rst_n = 1'b1;
    for (int a = 0; a < 48; a++) rd(8'(a));

    // R13: unmapped addresses
    cur_req = "R13";
    wr(8'h07, 8'hFF); rd(8'h07);
    wr(8'h01, 8'hFF); rd(8'h01);
    wr(8'hF0, 8'hFF); rd(8'hF0);
    wr(8'h33, 8'hFF); rd(8'h33); rd(8'h04);

    // R2: config readback
    cur_req = "R2";
    wr(8'h00, 8'hFF); rd(8'h00);
    wr(8'h04, 8'hA5); wr(8'h05, 8'h3C); wr(8'h06, 8'hF0);
    wr(8'h08, 8'h5A); wr(8'h0A, 8'h81); wr(8'h0D, 8'h7E);
    wr(8'h1C, 8'h11); wr(8'h21, 8'h22); wr(8'h26, 8'h44);
    for (int a = 4; a < 40; a++) rd(8'(a));

    // R3 / R4: set and clear
    cur_req = "R3";
    wr(8'h10, 8'h0F); wr(8'h10, 8'hF0); wr(8'h12, 8'h81); rd(8'h10); rd(8'h12);
    cur_req = "R4";
    wr(8'h14, 8'h03); wr(8'h16, 8'h01); wr(8'h14, 8'h00); rd(8'h14);

    // R5: group enables gate output enable
    cur_req = "R5";
    wr(8'h00, 8'h01); idle(2);
    wr(8'h00, 8'h02); idle(2);
    wr(8'h00, 8'h03); idle(2);

    // clear event config
    cur_req = "R2";
    wr(8'h1C, 8'h00); wr(8'h21, 8'h00); wr(8'h26, 8'h00);
    wr(8'h2C, 8'hFF); wr(8'h2D, 8'hFF); wr(8'h2E, 8'hFF);

    // R6: synchronized level readback
    cur_req = "R6";
    rd(8'h18);
    gpio_in = 24'hC3_5A_96; rd(8'h18); rd(8'h18); rd(8'h18); rd(8'h19); rd(8'h1A);
    gpio_in = 24'h00_00_00; rd(8'h18); rd(8'h18); rd(8'h18);

    // R7: edge events on byte 0, low nibble rising, high nibble falling
    cur_req = "R7";
    wr(8'h24, 8'hFF); wr(8'h20, 8'h0F); wr(8'h1C, 8'hFF);
    gpio_in[7:0] = 8'hFF; rd(8'h28); rd(8'h28); rd(8'h28); rd(8'h28);
    wr(8'h2C, 8'hFF); rd(8'h28);
    gpio_in[7:0] = 8'h00; rd(8'h28); rd(8'h28); rd(8'h28); rd(8'h28);

    // R9: partial acknowledge
    cur_req = "R9";
    wr(8'h2C, 8'h30); rd(8'h28);
    wr(8'h2C, 8'h00); rd(8'h28);
    wr(8'h2C, 8'hC0); rd(8'h28);

    // R10: acknowledge on the edge the event lands
    cur_req = "R10";
    gpio_in[0] = 1'b1; idle(2);
    wr(8'h2C, 8'h01); rd(8'h28); rd(8'h28);
    cur_req = "R11";
    wr(8'h2C, 8'h01); rd(8'h28);

    // R8: level mode on byte 1, active high
    cur_req = "R8";
    wr(8'h25, 8'h00); wr(8'h21, 8'hFF); wr(8'h1D, 8'h01);
    gpio_in[8] = 1'b1; idle(3); rd(8'h29);
    cur_req = "R10";
    wr(8'h2D, 8'h01); rd(8'h29);
    cur_req = "R8";
    gpio_in[8] = 1'b0; idle(3);
    wr(8'h2D, 8'h01); rd(8'h29); rd(8'h29);

    // R12: disabled event enable and disabled alternate group
    cur_req = "R12";
    wr(8'h1D, 8'h00);
    gpio_in[8] = 1'b1; idle(4); rd(8'h29);
    wr(8'h26, 8'hFF); wr(8'h22, 8'hFF); wr(8'h1E, 8'hFF);
    wr(8'h00, 8'h01);
    gpio_in[23:16] = 8'hFF; idle(4); rd(8'h2A);
    gpio_in[23:16] = 8'h00; idle(4); rd(8'h2A);
    wr(8'h00, 8'h03);
    gpio_in[23:16] = 8'h0F; idle(4); rd(8'h2A);
    cur_req = "R11";
    wr(8'h2E, 8'hFF); rd(8'h2A);

    // mixed random traffic
    cur_req = "R9";
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 3) == 0) gpio_in = PW'($urandom);
      if ($urandom_range(0, 1) == 0) wr(8'($urandom_range(0, 48)), 8'($urandom));
      else                           rd(8'($urandom_range(0, 48)));
    end

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule